// File: doc/BRIEF.md
# Three-Port Bridge Address Routing Decoder

This block decides where a transaction should go in a bridge that joins one upstream (primary) bus to two downstream (secondary) buses. Each cycle it can accept one request. A request carries a 32-bit address, a flag that marks it as I/O or memory, and a code for the port that started it. One clock later the block returns a one-hot route: secondary 1, secondary 2, primary, or no claim. The address comes out unchanged beside the route.

Each secondary port owns three address windows. One is for I/O. One is for memory that must not be prefetched. One is for prefetchable memory. Each window is a base and a limit supplied as plain inputs. Two command enables gate the result. The I/O enable gates I/O requests that start on the primary bus. The master enable gates every request that starts on a secondary bus.

When a request from one secondary bus misses its own windows but falls in the other secondary's window, it is sent across to that peer. It is not sent upstream.

Top module: `arw_route_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `route_valid` is 0 and `route_onehot` is 4'b0000.
- R2: A window matches an address A when base <= A <= limit, with both ends inclusive. A window whose base is greater than its limit matches no address.
- R3: A primary request (source code 0) that hits a window of a secondary port is routed to that port. A primary request that hits no window gets no claim. An I/O request is compared only against I/O windows. A memory request matches if it falls in either the non-prefetchable or the prefetchable window.
- R4: When a primary request hits windows of both secondary ports, secondary 1 wins.
- R5: When `io_en` is 0, a primary I/O request gets no claim. Primary memory requests are not affected by `io_en`.
- R6: When `master_en` is 0, every request from secondary 1 (code 1) or secondary 2 (code 2) gets no claim.
- R7: A secondary request that hits no window of either secondary port is routed to the primary bus.
- R8: A request from one secondary port that misses its own windows and hits the other secondary's window is routed to that other secondary.
- R9: A secondary request that hits its own port's window gets no claim.
- R10: The result appears exactly one clock after the request. `route_addr` then equals the request address. `route_onehot` has exactly one bit set, with bit 0 = secondary 1, bit 1 = secondary 2, bit 2 = primary and bit 3 = no claim.
- R11: A cycle with `req_valid` low gives `route_valid` 0 and `route_onehot` 4'b0000 on the next cycle.
- R12: A request with the reserved source code 3 gets no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 = I/O, 0 = memory |
| req_src | input | 2 | Originating port: 0 primary, 1 secondary 1, 2 secondary 2, 3 reserved |
| io_en | input | 1 | I/O enable for primary-initiated requests |
| master_en | input | 1 | Enable for secondary-initiated requests |
| s1_io_base | input | 32 | Secondary 1 I/O window base |
| s1_io_limit | input | 32 | Secondary 1 I/O window limit |
| s1_np_base | input | 32 | Secondary 1 non-prefetchable memory base |
| s1_np_limit | input | 32 | Secondary 1 non-prefetchable memory limit |
| s1_pf_base | input | 32 | Secondary 1 prefetchable memory base |
| s1_pf_limit | input | 32 | Secondary 1 prefetchable memory limit |
| s2_io_base | input | 32 | Secondary 2 I/O window base |
| s2_io_limit | input | 32 | Secondary 2 I/O window limit |
| s2_np_base | input | 32 | Secondary 2 non-prefetchable memory base |
| s2_np_limit | input | 32 | Secondary 2 non-prefetchable memory limit |
| s2_pf_base | input | 32 | Secondary 2 prefetchable memory base |
| s2_pf_limit | input | 32 | Secondary 2 prefetchable memory limit |
| route_valid | output | 1 | A route result is present |
| route_onehot | output | 4 | One-hot route: S1, S2, primary, no claim |
| route_addr | output | 32 | Request address, passed through unchanged |

## Verification
Directed requests are placed at each window's base, base minus one, limit and limit plus one. These tell inclusive bounds apart from exclusive ones. An empty window (base above limit) shows that reversed bounds never match. The same address is sent as both I/O and memory, which separates per-type window selection. It is also sent from each of the three sources, which separates downstream, peer, own-window and upstream routing. Overlapping windows expose the priority order. Toggling both enables shows which sources each enable gates. A long run of random requests, biased toward window edges and with the enables changing now and then, is compared against a behavioural model on every cycle.

// File: rtl/arw_pkg.sv
package arw_pkg;
   // Source port codes
   localparam logic [1:0] SRC_PRI = 2'd0;
   localparam logic [1:0] SRC_S1  = 2'd1;
   localparam logic [1:0] SRC_S2  = 2'd2;

   // Number of secondary ports and window kinds per port
   localparam int N_SEC     = 2;
   localparam int N_KIND    = 3;
   localparam int KIND_IO   = 0;
   localparam int KIND_NP   = 1;
   localparam int KIND_PF   = 2;

   // Route vector bit positions
   localparam int RT_W    = 4;
   localparam int RT_S1   = 0;
   localparam int RT_S2   = 1;
   localparam int RT_PRI  = 2;
   localparam int RT_NONE = 3;

   typedef logic [RT_W-1:0] route_t;
endpackage

// File: rtl/arw_window_cmp.sv
module arw_window_cmp #(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] limit,
   output logic              hit
);
   // Inclusive on both ends; a reversed window cannot satisfy both compares
   logic ge_base;
   logic le_limit;
   assign ge_base  = (addr >= base);
   assign le_limit = (addr <= limit);
   assign hit      = ge_base && le_limit;
endmodule

// File: rtl/arw_port_match.sv
module arw_port_match
   import arw_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [ADDR_W-1:0]             addr,
   input  logic                          is_io,
   input  logic [N_KIND-1:0][ADDR_W-1:0] base,
   input  logic [N_KIND-1:0][ADDR_W-1:0] limit,
   output logic                          hit
);
   logic [N_KIND-1:0] kind_hit;

   for (genvar k = 0; k < N_KIND; k++) begin : g_kind
      arw_window_cmp #(.ADDR_W(ADDR_W)) u_cmp (
         .addr  (addr),
         .base  (base[k]),
         .limit (limit[k]),
         .hit   (kind_hit[k])
      );
   end

   logic io_hit;
   logic mem_hit;
   assign io_hit  = kind_hit[KIND_IO];
   assign mem_hit = kind_hit[KIND_NP] | kind_hit[KIND_PF];
   assign hit     = is_io ? io_hit : mem_hit;
endmodule

// File: rtl/arw_route_sel.sv
module arw_route_sel
   import arw_pkg::*;
(
   input  logic [1:0]       src,
   input  logic             is_io,
   input  logic [N_SEC-1:0] sec_hit,
   input  logic             io_en,
   input  logic             master_en,
   output route_t           route
);
   always_comb begin
      route = '0;
      unique case (src)
         SRC_PRI: begin
            if (is_io && !io_en)  route[RT_NONE] = 1'b1;
            else if (sec_hit[0])  route[RT_S1]   = 1'b1;
            else if (sec_hit[1])  route[RT_S2]   = 1'b1;
            else                  route[RT_NONE] = 1'b1;
         end
         SRC_S1: begin
            if (!master_en)       route[RT_NONE] = 1'b1;
            else if (sec_hit[0])  route[RT_NONE] = 1'b1;
            else if (sec_hit[1])  route[RT_S2]   = 1'b1;
            else                  route[RT_PRI]  = 1'b1;
         end
         SRC_S2: begin
            if (!master_en)       route[RT_NONE] = 1'b1;
            else if (sec_hit[1])  route[RT_NONE] = 1'b1;
            else if (sec_hit[0])  route[RT_S1]   = 1'b1;
            else                  route[RT_PRI]  = 1'b1;
         end
         default:                 route[RT_NONE] = 1'b1;
      endcase
   end
endmodule

// File: rtl/arw_route_decoder.sv
module arw_route_decoder
   import arw_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_is_io,
   input  logic [1:0]        req_src,
   input  logic              io_en,
   input  logic              master_en,
   input  logic [ADDR_W-1:0] s1_io_base,
   input  logic [ADDR_W-1:0] s1_io_limit,
   input  logic [ADDR_W-1:0] s1_np_base,
   input  logic [ADDR_W-1:0] s1_np_limit,
   input  logic [ADDR_W-1:0] s1_pf_base,
   input  logic [ADDR_W-1:0] s1_pf_limit,
   input  logic [ADDR_W-1:0] s2_io_base,
   input  logic [ADDR_W-1:0] s2_io_limit,
   input  logic [ADDR_W-1:0] s2_np_base,
   input  logic [ADDR_W-1:0] s2_np_limit,
   input  logic [ADDR_W-1:0] s2_pf_base,
   input  logic [ADDR_W-1:0] s2_pf_limit,
   output logic              route_valid,
   output logic [RT_W-1:0]   route_onehot,
   output logic [ADDR_W-1:0] route_addr
);
   if (ADDR_W < 4 || ADDR_W > 64) begin : g_bad_width
      $error("arw_route_decoder: ADDR_W must be within 4..64");
   end

   // Pack window bounds per secondary port
   logic [N_SEC-1:0][N_KIND-1:0][ADDR_W-1:0] win_base;
   logic [N_SEC-1:0][N_KIND-1:0][ADDR_W-1:0] win_limit;

   assign win_base[0][KIND_IO]  = s1_io_base;
   assign win_base[0][KIND_NP]  = s1_np_base;
   assign win_base[0][KIND_PF]  = s1_pf_base;
   assign win_limit[0][KIND_IO] = s1_io_limit;
   assign win_limit[0][KIND_NP] = s1_np_limit;
   assign win_limit[0][KIND_PF] = s1_pf_limit;
   assign win_base[1][KIND_IO]  = s2_io_base;
   assign win_base[1][KIND_NP]  = s2_np_base;
   assign win_base[1][KIND_PF]  = s2_pf_base;
   assign win_limit[1][KIND_IO] = s2_io_limit;
   assign win_limit[1][KIND_NP] = s2_np_limit;
   assign win_limit[1][KIND_PF] = s2_pf_limit;

   logic [N_SEC-1:0] sec_hit;

   for (genvar p = 0; p < N_SEC; p++) begin : g_port
      arw_port_match #(.ADDR_W(ADDR_W)) u_match (
         .addr  (req_addr),
         .is_io (req_is_io),
         .base  (win_base[p]),
         .limit (win_limit[p]),
         .hit   (sec_hit[p])
      );
   end

   route_t next_route;

   arw_route_sel u_sel (
      .src       (req_src),
      .is_io     (req_is_io),
      .sec_hit   (sec_hit),
      .io_en     (io_en),
      .master_en (master_en),
      .route     (next_route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_valid  <= 1'b0;
         route_onehot <= '0;
         route_addr   <= '0;
      end else begin
         route_valid  <= req_valid;
         route_onehot <= req_valid ? next_route : '0;
         route_addr   <= req_addr;
      end
   end

   // R10: one-hot result with the address carried through
   a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> $countones(route_onehot) == 1);
   a_r10_addr_pass: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> route_addr == $past(req_addr));
   // R11: idle cycle leaves no result
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!route_valid && route_onehot == '0));
   // R5: primary I/O blocked by io_en
   a_r5_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src == SRC_PRI && req_is_io && !io_en)
      |=> route_onehot[RT_NONE]);
   // R6: secondary traffic blocked by master_en
   a_r6_master_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (req_src == SRC_S1 || req_src == SRC_S2) && !master_en)
      |=> route_onehot[RT_NONE]);
   // R8: peer forwarding from secondary 1
   a_r8_peer_s1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src == SRC_S1 && master_en && !sec_hit[0] && sec_hit[1])
      |=> route_onehot[RT_S2]);
   // R9: own-window hit from secondary 2 is not claimed
   a_r9_own_s2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src == SRC_S2 && sec_hit[1])
      |=> route_onehot[RT_NONE]);
   // R4: secondary 1 wins overlap on primary requests
   a_r4_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_src == SRC_PRI && (io_en || !req_is_io) && sec_hit[0])
      |=> route_onehot[RT_S1]);
endmodule

// File: tb/arw_route_decoder_tb_top.sv
`timescale 1ns/1ps
module arw_route_decoder_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_is_io = 1'b0;
   logic [1:0]  req_src = 2'd0;
   logic        io_en = 1'b1;
   logic        master_en = 1'b1;
   logic [31:0] s1_io_b, s1_io_l, s1_np_b, s1_np_l, s1_pf_b, s1_pf_l;
   logic [31:0] s2_io_b, s2_io_l, s2_np_b, s2_np_l, s2_pf_b, s2_pf_l;
   logic        route_valid;
   logic [3:0]  route_onehot;
   logic [31:0] route_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   arw_route_decoder dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_is_io(req_is_io), .req_src(req_src), .io_en(io_en), .master_en(master_en),
      .s1_io_base(s1_io_b), .s1_io_limit(s1_io_l), .s1_np_base(s1_np_b),
      .s1_np_limit(s1_np_l), .s1_pf_base(s1_pf_b), .s1_pf_limit(s1_pf_l),
      .s2_io_base(s2_io_b), .s2_io_limit(s2_io_l), .s2_np_base(s2_np_b),
      .s2_np_limit(s2_np_l), .s2_pf_base(s2_pf_b), .s2_pf_limit(s2_pf_l),
      .route_valid(route_valid), .route_onehot(route_onehot), .route_addr(route_addr)
   );

   function automatic bit inwin(input logic [31:0] a, input logic [31:0] b, input logic [31:0] l);
      return (a >= b) && (a <= l);
   endfunction

   // Behavioural reference: route bits S1=0, S2=1, PRI=2, NONE=3
   function automatic void model(input bit v, input int src, input bit io,
                                 input logic [31:0] a, output logic [3:0] r, output string tag);
      bit h1, h2;
      h1 = io ? inwin(a, s1_io_b, s1_io_l) : (inwin(a, s1_np_b, s1_np_l) || inwin(a, s1_pf_b, s1_pf_l));
      h2 = io ? inwin(a, s2_io_b, s2_io_l) : (inwin(a, s2_np_b, s2_np_l) || inwin(a, s2_pf_b, s2_pf_l));
      if (!v) begin r = 4'b0000; tag = "R11"; end
      else if (src == 0) begin
         if (io && !io_en)  begin r = 4'b1000; tag = "R5"; end
         else if (h1 && h2) begin r = 4'b0001; tag = "R4"; end
         else if (h1)       begin r = 4'b0001; tag = "R3"; end
         else if (h2)       begin r = 4'b0010; tag = "R3"; end
         else               begin r = 4'b1000; tag = "R3"; end
      end else if (src == 1 || src == 2) begin
         bit own, peer;
         own  = (src == 1) ? h1 : h2;
         peer = (src == 1) ? h2 : h1;
         if (!master_en) begin r = 4'b1000; tag = "R6"; end
         else if (own)   begin r = 4'b1000; tag = "R9"; end
         else if (peer)  begin r = (src == 1) ? 4'b0010 : 4'b0001; tag = "R8"; end
         else            begin r = 4'b0100; tag = "R7"; end
      end else begin r = 4'b1000; tag = "R12"; end
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Drive at negedge, compare at next negedge (one register of latency)
   task automatic apply(input bit v, input int src, input bit io, input logic [31:0] a,
                        input string force_tag = "");
      logic [3:0] er;
      string tag;
      req_valid = v; req_src = src[1:0]; req_is_io = io; req_addr = a;
      model(v, src, io, a, er, tag);
      if (force_tag != "") tag = force_tag;
      @(negedge clk);
      chk({tag, " route"}, {28'd0, route_onehot}, {28'd0, er});
      chk({tag, " valid"}, {31'd0, route_valid}, {31'd0, v});
      if (v) chk("R10 addr", route_addr, a);
   endtask

   task automatic base_cfg();
      s1_io_b = 32'h0000_1000; s1_io_l = 32'h0000_1FFF;
      s1_np_b = 32'h8000_0000; s1_np_l = 32'h8FFF_FFFF;
      s1_pf_b = 32'hA000_0000; s1_pf_l = 32'hAFFF_FFFF;
      s2_io_b = 32'h0000_2000; s2_io_l = 32'h0000_2FFF;
      s2_np_b = 32'h9000_0000; s2_np_l = 32'h9FFF_FFFF;
      s2_pf_b = 32'hB000_0000; s2_pf_l = 32'hBFFF_FFFF;
   endtask

   function automatic logic [31:0] pick_addr();
      logic [31:0] b, l;
      case ($urandom % 6)
         0: begin b = s1_io_b; l = s1_io_l; end
         1: begin b = s1_np_b; l = s1_np_l; end
         2: begin b = s1_pf_b; l = s1_pf_l; end
         3: begin b = s2_io_b; l = s2_io_l; end
         4: begin b = s2_np_b; l = s2_np_l; end
         default: begin b = s2_pf_b; l = s2_pf_l; end
      endcase
      case ($urandom % 6)
         0: return b - 1;
         1: return b;
         2: return l;
         3: return l + 1;
         4: return b + ((l - b) >> 1);
         default: return $urandom;
      endcase
   endfunction

   initial begin
      #(5.0 * 150000);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      base_cfg();
      repeat (3) @(negedge clk);
      chk("R1 reset valid", {31'd0, route_valid}, 32'd0);
      chk("R1 reset route", {28'd0, route_onehot}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset valid", {31'd0, route_valid}, 32'd0);
      chk("R1 after reset route", {28'd0, route_onehot}, 32'd0);

      // R2 inclusive bounds, primary I/O
      apply(1, 0, 1, 32'h0000_0FFF, "R2");
      apply(1, 0, 1, 32'h0000_1000, "R2");
      apply(1, 0, 1, 32'h0000_1FFF, "R2");
      apply(1, 0, 1, 32'h0000_3000, "R2");
      // R3 type selection: same address as memory misses I/O windows
      apply(1, 0, 0, 32'h0000_1800, "R3");
      apply(1, 0, 0, 32'hA000_0000, "R3");
      apply(1, 0, 0, 32'hB123_4567, "R3");
      apply(1, 0, 0, 32'h9FFF_FFFF, "R3");
      // R11 idle cycle
      apply(0, 0, 0, 32'h8000_0000, "R11");
      // R7 upstream, R8 peer, R9 own
      apply(1, 1, 0, 32'h0000_0000, "R7");
      apply(1, 2, 1, 32'hFFFF_FFFF, "R7");
      apply(1, 1, 0, 32'h9000_0000, "R8");
      apply(1, 2, 1, 32'h0000_1234, "R8");
      apply(1, 1, 1, 32'h0000_1FFF, "R9");
      apply(1, 2, 0, 32'hBFFF_FFFF, "R9");
      // R12 reserved source
      apply(1, 3, 0, 32'h8000_0000, "R12");
      // R5 io enable gating
      io_en = 1'b0;
      apply(1, 0, 1, 32'h0000_1000, "R5");
      apply(1, 0, 0, 32'h8000_0000, "R5");
      apply(1, 1, 1, 32'h0000_0000, "R5");
      io_en = 1'b1;
      // R6 master enable gating
      master_en = 1'b0;
      apply(1, 1, 0, 32'h0000_0000, "R6");
      apply(1, 2, 0, 32'h8000_0000, "R6");
      apply(1, 0, 0, 32'h8000_0000, "R6");
      master_en = 1'b1;
      // R4 overlap priority
      s2_io_b = 32'h0000_1800;
      apply(1, 0, 1, 32'h0000_1900, "R4");
      apply(1, 0, 1, 32'h0000_2000, "R4");
      // R2 empty window: base above limit
      base_cfg();
      s2_pf_b = 32'hB000_0001; s2_pf_l = 32'hB000_0000;
      apply(1, 0, 0, 32'hB000_0000, "R2");
      apply(1, 0, 0, 32'hB000_0001, "R2");
      apply(1, 1, 0, 32'hB000_0000, "R2");
      base_cfg();

      // Random phase against the model
      for (int i = 0; i < 3000; i++) begin
         if (i % 97 == 0) begin io_en = $urandom; master_en = $urandom; end
         if (i == 1500) begin s1_np_b = 32'h9800_0000; s2_io_l = 32'h0000_0FFF; end
         apply(($urandom % 8) != 0, $urandom % 4, $urandom, pick_addr());
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule